// File: doc/BRIEF.md
# Directory-Protocol Cache Coherence Controller

This block is the coherence logic that sits beside one processor's private cache in a system where a home directory, not a shared bus, keeps copies consistent. Every line of a small direct-mapped store holds a tag, a block of data and one of three coherence states: Invalid, Shared (read-only copy) or Exclusive (the only copy, writable). CPU reads and writes that the line can serve finish locally. All other accesses become a read-miss or write-miss message to the directory. The CPU response is then held back until the directory returns the whole block in a data reply.

The directory may also send three probe messages: invalidate, fetch, and fetch-with-invalidate. The controller answers a fetch on an owned block with a write-back carrying the block address and the full block. It sends the same write-back when an owned block has to leave its line because a different block maps to the same index. A Shared line that is replaced is simply overwritten. All three data paths (CPU request/response, outgoing messages, incoming messages) are valid/ready streams. A transfer happens on a clock edge where both valid and ready are high. A source that raises valid holds it, together with its payload, until the transfer happens.

Top module: `coh_cache_ctrl`

## Requirements
- R1: After reset every line is Invalid. The block then accepts CPU requests and incoming messages, and drives no outgoing message and no response.
- R2: A CPU read whose line is Invalid or holds another block sends a read-miss message (type 0) with the block address (CPU address without the word offset). It waits for a data reply (incoming type 3), installs the block as Shared, and responds with the requested word from the reply.
- R3: A CPU write to a block not held Exclusive sends a write-miss message (type 1) and waits for the reply carrying the whole block. It installs that block as Exclusive, with the written word merged in at the word offset, and responds with the written word.
- R4: A read to a line that is Shared or Exclusive with a matching tag, and a write to a matching Exclusive line, respond with no outgoing message. A write updates only the addressed word.
- R5: An invalidate (incoming type 0) for a block held Shared makes the line Invalid, so the next read of it misses. Probes for a block not held change nothing and send nothing.
- R6: A fetch (incoming type 1) for a block held Exclusive sends a write-back (type 2) with the block address and current data, and leaves the line Shared. A fetch for a block not held Exclusive sends nothing.
- R7: A fetch-with-invalidate (incoming type 2) for a block held Exclusive sends a write-back with the current data and leaves the line Invalid.
- R8: A miss whose line holds a different block in Exclusive first sends a write-back of that block (address formed from the old tag and the index). The miss message follows it.
- R9: A miss whose line holds a different block in Shared sends only the miss message, with no write-back.
- R10: Outgoing message and response payloads stay stable while their ready input is low. In the idle state an incoming message takes priority over a CPU request, which is refused in that cycle.
- R11: While a miss is outstanding, no response is given, and only a data reply is accepted on the incoming port. The response follows the accepted reply by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req_valid | input | 1 | CPU request valid |
| cpu_req_ready | output | 1 | Controller can take a CPU request |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | AW | Word address: tag, index, word offset (low bits) |
| cpu_req_wdata | input | WORD_W | Write data |
| cpu_rsp_valid | output | 1 | Response valid |
| cpu_rsp_ready | input | 1 | CPU takes the response |
| cpu_rsp_rdata | output | WORD_W | Read word, or the written word for writes |
| out_valid | output | 1 | Outgoing message valid |
| out_ready | input | 1 | Network takes the outgoing message |
| out_type | output | 2 | 0 read miss, 1 write miss, 2 write-back |
| out_baddr | output | AW-log2(WORDS) | Block address |
| out_data | output | WORDS*WORD_W | Block data (write-back only), word 0 in the low bits |
| in_valid | input | 1 | Incoming message valid |
| in_ready | output | 1 | Controller takes the incoming message |
| in_type | input | 2 | 0 invalidate, 1 fetch, 2 fetch-with-invalidate, 3 data reply |
| in_baddr | input | AW-log2(WORDS) | Block address |
| in_data | input | WORDS*WORD_W | Block data (data reply) |

## Verification
On every cycle, the assertions check the stream rules: held payloads under back-pressure, probe priority over CPU requests, no response while a message is pending, and a response one cycle after a reply. The state transitions of the lines can only be seen through the bench's scenarios. The bench keeps its own model of line states and directory memory, and compares every miss, write-back and returned word against it. That covers conflict evictions, both kinds of silent case, and probe followed by access.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    OM_RDMISS = 2'd0,
    OM_WRMISS = 2'd1,
    OM_WRBACK = 2'd2
  } out_msg_e;

  typedef enum logic [1:0] {
    IM_INVAL    = 2'd0,
    IM_FETCH    = 2'd1,
    IM_FETCH_IV = 2'd2,
    IM_DATA     = 2'd3
  } in_msg_e;

  typedef enum logic [2:0] {
    F_IDLE,
    F_EVICT,
    F_MISS,
    F_WAIT,
    F_RESP,
    F_PROBE_WB
  } ctl_st_e;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int LINES = 4,
  parameter int TAG_W = 4,
  parameter int BLK_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [TAG_W-1:0] ra_tag,
  output line_st_e         ra_st,
  output logic [BLK_W-1:0] ra_dat,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [TAG_W-1:0] rb_tag,
  output line_st_e         rb_st,
  output logic [BLK_W-1:0] rb_dat,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  logic [TAG_W-1:0] w_tag,
  input  line_st_e         w_st,
  input  logic [BLK_W-1:0] w_dat
);
  logic [TAG_W-1:0] tag_q [LINES];
  line_st_e         st_q  [LINES];
  logic [BLK_W-1:0] dat_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        tag_q[i] <= '0;
        st_q[i]  <= LS_INV;
        dat_q[i] <= '0;
      end
    end else if (we) begin
      tag_q[w_idx] <= w_tag;
      st_q[w_idx]  <= w_st;
      dat_q[w_idx] <= w_dat;
    end
  end

  assign ra_tag = tag_q[ra_idx];
  assign ra_st  = st_q[ra_idx];
  assign ra_dat = dat_q[ra_idx];
  assign rb_tag = tag_q[rb_idx];
  assign rb_st  = st_q[rb_idx];
  assign rb_dat = dat_q[rb_idx];
endmodule

// File: rtl/coh_word_lane.sv
module coh_word_lane #(
  parameter int WORDS  = 4,
  parameter int WORD_W = 8,
  localparam int OFF_W = $clog2(WORDS),
  localparam int BLK_W = WORDS * WORD_W
) (
  input  logic [BLK_W-1:0]  base,
  input  logic [OFF_W-1:0]  off,
  input  logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] pick,
  output logic [BLK_W-1:0]  merged
);
  for (genvar g = 0; g < WORDS; g++) begin : g_lane
    assign merged[g*WORD_W +: WORD_W] =
      (off == OFF_W'(g)) ? word : base[g*WORD_W +: WORD_W];
  end

  assign pick = base[off*WORD_W +: WORD_W];
endmodule

// File: rtl/coh_cache_ctrl.sv
module coh_cache_ctrl
  import coh_pkg::*;
#(
  parameter int AW     = 8,
  parameter int WORDS  = 4,
  parameter int WORD_W = 8,
  parameter int LINES  = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cpu_req_valid,
  output logic                             cpu_req_ready,
  input  logic                             cpu_req_we,
  input  logic [AW-1:0]                    cpu_req_addr,
  input  logic [WORD_W-1:0]                cpu_req_wdata,
  output logic                             cpu_rsp_valid,
  input  logic                             cpu_rsp_ready,
  output logic [WORD_W-1:0]                cpu_rsp_rdata,
  output logic                             out_valid,
  input  logic                             out_ready,
  output logic [1:0]                       out_type,
  output logic [AW-$clog2(WORDS)-1:0]      out_baddr,
  output logic [WORDS*WORD_W-1:0]          out_data,
  input  logic                             in_valid,
  output logic                             in_ready,
  input  logic [1:0]                       in_type,
  input  logic [AW-$clog2(WORDS)-1:0]      in_baddr,
  input  logic [WORDS*WORD_W-1:0]          in_data
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int BA_W  = AW - OFF_W;
  localparam int TAG_W = BA_W - IDX_W;
  localparam int BLK_W = WORDS * WORD_W;

  ctl_st_e             fsm_q;
  logic                req_we_q;
  logic [AW-1:0]       req_addr_q;
  logic [WORD_W-1:0]   req_wdata_q;
  logic [WORD_W-1:0]   rsp_q;
  out_msg_e            omsg_q;
  logic [BA_W-1:0]     obaddr_q;
  logic [BLK_W-1:0]    odata_q;

  // address fields of the live request and of the held request
  logic [OFF_W-1:0] c_off, q_off;
  logic [IDX_W-1:0] c_idx, q_idx, p_idx;
  logic [TAG_W-1:0] c_tag, q_tag, p_tag;
  assign c_off = cpu_req_addr[OFF_W-1:0];
  assign c_idx = cpu_req_addr[OFF_W +: IDX_W];
  assign c_tag = cpu_req_addr[AW-1 -: TAG_W];
  assign q_off = req_addr_q[OFF_W-1:0];
  assign q_idx = req_addr_q[OFF_W +: IDX_W];
  assign q_tag = req_addr_q[AW-1 -: TAG_W];
  assign p_idx = in_baddr[IDX_W-1:0];
  assign p_tag = in_baddr[BA_W-1 -: TAG_W];

  in_msg_e in_kind;
  assign in_kind = in_msg_e'(in_type);

  logic idle, cpu_take, probe_take, reply_take;
  assign idle          = (fsm_q == F_IDLE);
  assign cpu_req_ready = idle && !in_valid;
  assign in_ready      = idle || ((fsm_q == F_WAIT) && (in_kind == IM_DATA));
  assign cpu_take      = cpu_req_valid && cpu_req_ready;
  assign probe_take    = idle && in_valid;
  assign reply_take    = (fsm_q == F_WAIT) && in_valid && (in_kind == IM_DATA);

  // line store
  logic [TAG_W-1:0] a_tag, b_tag, w_tag;
  line_st_e         a_st, b_st, w_st;
  logic [BLK_W-1:0] a_dat, b_dat, w_dat;
  logic [IDX_W-1:0] w_idx;
  logic             w_en;

  coh_line_store #(.LINES(LINES), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .ra_idx (idle ? c_idx : q_idx),
    .ra_tag (a_tag),
    .ra_st  (a_st),
    .ra_dat (a_dat),
    .rb_idx (p_idx),
    .rb_tag (b_tag),
    .rb_st  (b_st),
    .rb_dat (b_dat),
    .we     (w_en),
    .w_idx  (w_idx),
    .w_tag  (w_tag),
    .w_st   (w_st),
    .w_dat  (w_dat)
  );

  // word select and merge, shared by hits and by reply install
  logic [WORD_W-1:0] pick;
  logic [BLK_W-1:0]  merged;

  coh_word_lane #(.WORDS(WORDS), .WORD_W(WORD_W)) u_lane (
    .base   ((fsm_q == F_WAIT) ? in_data : a_dat),
    .off    (idle ? c_off : q_off),
    .word   (idle ? cpu_req_wdata : req_wdata_q),
    .pick   (pick),
    .merged (merged)
  );

  // lookup results
  logic a_present, a_hit, a_evict, p_present, p_wb;
  assign a_present = (a_st != LS_INV) && (a_tag == c_tag);
  assign a_hit     = a_present && (!cpu_req_we || (a_st == LS_EXC));
  assign a_evict   = !a_present && (a_st == LS_EXC);
  assign p_present = (b_st != LS_INV) && (b_tag == p_tag);
  assign p_wb      = probe_take && p_present && (b_st == LS_EXC) &&
                     ((in_kind == IM_FETCH) || (in_kind == IM_FETCH_IV));

  // single write port into the line store
  always_comb begin
    w_en  = 1'b0;
    w_idx = c_idx;
    w_tag = a_tag;
    w_st  = a_st;
    w_dat = a_dat;
    if (probe_take) begin
      w_idx = p_idx;
      w_tag = b_tag;
      w_st  = b_st;
      w_dat = b_dat;
      if (p_present) begin
        case (in_kind)
          IM_INVAL: if (b_st == LS_SHR) begin
            w_en = 1'b1;
            w_st = LS_INV;
          end
          IM_FETCH: if (b_st == LS_EXC) begin
            w_en = 1'b1;
            w_st = LS_SHR;
          end
          IM_FETCH_IV: if (b_st == LS_EXC) begin
            w_en = 1'b1;
            w_st = LS_INV;
          end
          default: ;
        endcase
      end
    end else if (cpu_take) begin
      if (a_hit && cpu_req_we) begin
        w_en  = 1'b1;
        w_dat = merged;
      end else if (a_evict) begin
        w_en = 1'b1;
        w_st = LS_INV;
      end
    end else if (reply_take) begin
      w_en  = 1'b1;
      w_idx = q_idx;
      w_tag = q_tag;
      w_st  = req_we_q ? LS_EXC : LS_SHR;
      w_dat = req_we_q ? merged : in_data;
    end
  end

  // sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q       <= F_IDLE;
      req_we_q    <= 1'b0;
      req_addr_q  <= '0;
      req_wdata_q <= '0;
      rsp_q       <= '0;
      omsg_q      <= OM_RDMISS;
      obaddr_q    <= '0;
      odata_q     <= '0;
    end else begin
      case (fsm_q)
        F_IDLE: begin
          if (probe_take) begin
            if (p_wb) begin
              omsg_q   <= OM_WRBACK;
              obaddr_q <= in_baddr;
              odata_q  <= b_dat;
              fsm_q    <= F_PROBE_WB;
            end
          end else if (cpu_take) begin
            req_we_q    <= cpu_req_we;
            req_addr_q  <= cpu_req_addr;
            req_wdata_q <= cpu_req_wdata;
            if (a_hit) begin
              rsp_q <= cpu_req_we ? cpu_req_wdata : pick;
              fsm_q <= F_RESP;
            end else if (a_evict) begin
              omsg_q   <= OM_WRBACK;
              obaddr_q <= {a_tag, c_idx};
              odata_q  <= a_dat;
              fsm_q    <= F_EVICT;
            end else begin
              omsg_q   <= cpu_req_we ? OM_WRMISS : OM_RDMISS;
              obaddr_q <= cpu_req_addr[AW-1:OFF_W];
              odata_q  <= '0;
              fsm_q    <= F_MISS;
            end
          end
        end
        F_EVICT: if (out_ready) begin
          omsg_q   <= req_we_q ? OM_WRMISS : OM_RDMISS;
          obaddr_q <= req_addr_q[AW-1:OFF_W];
          odata_q  <= '0;
          fsm_q    <= F_MISS;
        end
        F_MISS: if (out_ready) fsm_q <= F_WAIT;
        F_WAIT: if (reply_take) begin
          rsp_q <= req_we_q ? req_wdata_q : pick;
          fsm_q <= F_RESP;
        end
        F_RESP: if (cpu_rsp_ready) fsm_q <= F_IDLE;
        F_PROBE_WB: if (out_ready) fsm_q <= F_IDLE;
        default: fsm_q <= F_IDLE;
      endcase
    end
  end

  assign out_valid     = (fsm_q == F_EVICT) || (fsm_q == F_MISS) || (fsm_q == F_PROBE_WB);
  assign out_type      = omsg_q;
  assign out_baddr     = obaddr_q;
  assign out_data      = odata_q;
  assign cpu_rsp_valid = (fsm_q == F_RESP);
  assign cpu_rsp_rdata = rsp_q;

  // checks
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid && !cpu_rsp_ready |=> cpu_rsp_valid && $stable(cpu_rsp_rdata)); // R10
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_type) && $stable(out_baddr) && $stable(out_data)); // R10
  AST_PROBE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> !(cpu_req_valid && cpu_req_ready)); // R10
  AST_REPLY_THEN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_q == F_WAIT) && in_valid && in_ready |=> cpu_rsp_valid); // R11
  AST_NO_RSP_WITH_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !cpu_rsp_valid); // R11
  AST_WAIT_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_q == F_WAIT) && in_valid && (in_type != 2'd3) |-> !in_ready); // R11
endmodule

// File: tb/coh_cache_ctrl_test.sv
`timescale 1ns/1ps
module coh_cache_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0, cpu_req_we = 1'b0;
  logic [7:0]  cpu_req_addr = '0, cpu_req_wdata = '0;
  logic        cpu_req_ready, cpu_rsp_valid;
  logic        cpu_rsp_ready = 1'b1;
  logic [7:0]  cpu_rsp_rdata;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_type;
  logic [5:0]  out_baddr;
  logic [31:0] out_data;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_type = '0;
  logic [5:0]  in_baddr = '0;
  logic [31:0] in_data = '0;

  always #4 clk = ~clk;

  coh_cache_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr), .cpu_req_wdata(cpu_req_wdata),
    .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_ready(cpu_rsp_ready), .cpu_rsp_rdata(cpu_rsp_rdata),
    .out_valid(out_valid), .out_ready(out_ready), .out_type(out_type),
    .out_baddr(out_baddr), .out_data(out_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_type(in_type),
    .in_baddr(in_baddr), .in_data(in_data)
  );

  int nvec = 0, nerr = 0;

  // bench model: directory memory and expected line contents
  logic [31:0] memb  [64];
  int          m_st  [4];   // 0 invalid, 1 shared, 2 exclusive
  logic [3:0]  m_tag [4];
  logic [31:0] m_dat [4];

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wait_out();
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (out_valid) return;
      chk("R11 no response before message", {63'd0, cpu_rsp_valid}, 64'd0);
    end
    chk("R11 message timeout", 64'd0, 64'd1);
  endtask

  task automatic access(input bit we, input logic [7:0] a, input logic [7:0] wd,
                        input string ctx, input bit bp);
    int         idx = int'(a[3:2]);
    int         off = int'(a[1:0]);
    logic [3:0] tg  = a[7:4];
    logic [5:0] ba  = a[7:2];
    bit present = (m_st[idx] != 0) && (m_tag[idx] == tg);
    bit hit     = present && (!we || m_st[idx] == 2);
    bit ev      = !present && (m_st[idx] == 2);
    bit sev     = !present && (m_st[idx] == 1);
    string lm   = (ctx != "") ? ctx : (sev ? "R9" : (we ? "R3" : "R2"));
    string lr   = (ctx != "") ? ctx : (hit ? "R4" : (we ? "R3" : "R2"));
    logic [7:0] exp_w;
    logic [5:0] held;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_we = we; cpu_req_addr = a; cpu_req_wdata = wd;
    #1;
    while (!cpu_req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    cpu_req_valid = 1'b0;
    if (ev) begin
      wait_out();
      chk("R8 evict type", 64'(out_type), 64'd2);
      chk("R8 evict addr", 64'(out_baddr), 64'({m_tag[idx], 2'(idx)}));
      chk("R8 evict data", 64'(out_data), 64'(m_dat[idx]));
      @(posedge clk); #1;
      memb[{m_tag[idx], 2'(idx)}] = m_dat[idx];
      m_st[idx] = 0;
    end
    if (!hit) begin
      wait_out();
      chk({lm, " miss type"}, 64'(out_type), we ? 64'd1 : 64'd0);
      chk({lm, " miss addr"}, 64'(out_baddr), 64'(ba));
      if (bp) begin
        out_ready = 1'b0;
        held = out_baddr;
        repeat (3) begin
          @(negedge clk);
          chk("R10 message held", {63'd0, out_valid}, 64'd1);
          chk("R10 address held", 64'(out_baddr), 64'(held));
        end
        out_ready = 1'b1;
      end
      @(posedge clk); #1;
      @(negedge clk);
      chk("R11 no response before reply", {63'd0, cpu_rsp_valid}, 64'd0);
      in_valid = 1'b1; in_type = 2'd3; in_baddr = ba; in_data = memb[ba];
      #1;
      chk("R11 reply accepted", {63'd0, in_ready}, 64'd1);
      @(posedge clk); #1;
      in_valid = 1'b0;
      m_tag[idx] = tg;
      m_dat[idx] = memb[ba];
      m_st[idx]  = we ? 2 : 1;
    end
    if (we) m_dat[idx][off*8 +: 8] = wd;
    exp_w = m_dat[idx][off*8 +: 8];
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      if (hit) chk("R4 hit sends nothing", {63'd0, out_valid}, 64'd0);
      if (cpu_rsp_valid) break;
    end
    chk({lr, " response"}, 64'(cpu_rsp_rdata), 64'(exp_w));
    if (bp) begin
      cpu_rsp_ready = 1'b0;
      repeat (2) begin
        @(negedge clk);
        chk("R10 response held", {63'd0, cpu_rsp_valid}, 64'd1);
        chk("R10 response data held", 64'(cpu_rsp_rdata), 64'(exp_w));
      end
      cpu_rsp_ready = 1'b1;
    end
    @(posedge clk); #1;
  endtask

  task automatic probe(input int kind, input logic [5:0] ba, input bit with_cpu);
    int         idx = int'(ba[1:0]);
    logic [3:0] tg  = ba[5:2];
    bit present = (m_st[idx] != 0) && (m_tag[idx] == tg);
    bit wb      = present && (m_st[idx] == 2) && (kind == 1 || kind == 2);
    string lb   = (kind == 0) ? "R5" : ((kind == 1) ? "R6" : "R7");
    @(negedge clk);
    in_valid = 1'b1; in_type = 2'(kind); in_baddr = ba; in_data = '0;
    if (with_cpu) begin
      cpu_req_valid = 1'b1; cpu_req_we = 1'b0; cpu_req_addr = {ba, 2'b00};
    end
    #1;
    chk({lb, " probe accepted"}, {63'd0, in_ready}, 64'd1);
    if (with_cpu) chk("R10 probe before cpu", {63'd0, cpu_req_ready}, 64'd0);
    @(posedge clk); #1;
    in_valid = 1'b0;
    cpu_req_valid = 1'b0;
    if (wb) begin
      wait_out();
      chk({lb, " write-back type"}, 64'(out_type), 64'd2);
      chk({lb, " write-back addr"}, 64'(out_baddr), 64'(ba));
      chk({lb, " write-back data"}, 64'(out_data), 64'(m_dat[idx]));
      @(posedge clk); #1;
      memb[ba] = m_dat[idx];
      m_st[idx] = (kind == 1) ? 1 : 0;
    end else begin
      if (present && kind == 0 && m_st[idx] == 1) m_st[idx] = 0;
      repeat (2) begin
        @(negedge clk);
        chk({lb, " probe silent"}, {63'd0, out_valid}, 64'd0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    for (int b = 0; b < 64; b++)
      for (int w = 0; w < 4; w++)
        memb[b][w*8 +: 8] = 8'((b * 4 + w) * 7 + 3);
    for (int i = 0; i < 4; i++) begin
      m_st[i] = 0; m_tag[i] = '0; m_dat[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cpu ready", {63'd0, cpu_req_ready}, 64'd1);
    chk("R1 in ready", {63'd0, in_ready}, 64'd1);
    chk("R1 no message", {63'd0, out_valid}, 64'd0);
    chk("R1 no response", {63'd0, cpu_rsp_valid}, 64'd0);

    // all lines empty: first reads miss
    for (int i = 0; i < 4; i++)
      access(1'b0, {4'd3, 2'(i), 2'd1}, 8'd0, "R1", 1'b0);

    // mixed sweep: conflicts, hits, upgrades, evictions
    for (int i = 0; i < 96; i++) begin
      logic [3:0] tg = 4'((i * 7) % 5);
      logic [1:0] ix = 2'((i / 2) % 4);
      logic [1:0] of = 2'(i % 4);
      access((i % 3) == 0, {tg, ix, of}, 8'(i * 11 + 2), "", 1'b0);
    end

    // probe sequences on each line
    for (int i = 0; i < 4; i++) begin
      logic [3:0] tg = 4'(8 + i);
      logic [7:0] a  = {tg, 2'(i), 2'(i)};
      access(1'b0, a, 8'd0, "", 1'b0);
      probe(0, {tg, 2'(i)}, 1'b0);
      access(1'b0, a, 8'd0, "R5", 1'b0);
      probe(1, {tg, 2'(i)}, 1'b0);
      access(1'b1, a, 8'(8'hA0 + i), "", 1'b0);
      probe(1, {tg, 2'(i)}, 1'b0);
      access(1'b0, a, 8'd0, "R6", 1'b0);
      access(1'b1, a, 8'(8'hB0 + i), "R6", 1'b0);
      probe(2, {tg, 2'(i)}, 1'b0);
      access(1'b0, a, 8'd0, "R7", 1'b0);
      for (int k = 0; k < 3; k++) probe(k, {~tg, 2'(i)}, 1'b0);
      access(1'b0, a, 8'd0, "R5", 1'b0);
      probe(2, {tg, 2'(i)}, 1'b0);
    end

    // back-pressure and priority
    access(1'b1, 8'h5A, 8'h77, "", 1'b1);
    access(1'b0, 8'h9A, 8'h00, "", 1'b1);
    probe(1, 6'h16, 1'b1);
    probe(0, 6'h26, 1'b1);
    access(1'b0, 8'h5B, 8'h00, "", 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule